// File: doc/BRIEF.md
# SPI serial memory slave interface

This block is the slave side of a serial peripheral bus for a byte-wide memory. It has no busy period. A host selects the block, then shifts in an 8-bit command, MSB first. Some commands are followed by a two-byte address and then a stream of data bytes. Read data and status come back on a serial output that the block drives only while it is returning data. The array is modelled as synchronous single-port RAM. Writes land in the array as soon as each byte is complete, so the host never polls.

All interface pins are sampled by a fast system clock through synchronisers. Edges of the serial clock are found from the sampled level. Both idle polarities of the serial clock are accepted: clock idling low with data on the first edge, and clock idling high with data on the second edge. Incoming bits are taken on the rising edge of the serial clock. Outgoing bits change on its falling edge.

A pause input freezes a transfer in the middle of a byte without deselecting the block. A write-protect input locks the writable status bits. The bus has no back-pressure. The host owns the serial clock and the block keeps pace, so the pins carry no valid/ready pair.

Top module: `spi_mem_slave`

## Requirements
- R1: Transfers work with the serial clock idling low and with it idling high. SI is captured on each rising SCK edge and SO changes after each falling SCK edge.
- R2: While cs_n is high, so_oe is low and SCK/SI activity has no effect. Raising cs_n aborts the transfer, and a partly received data byte is never written.
- R3: Command 0x06 sets the write-enable latch. Command 0x04 clears it when cs_n rises, as do commands 0x02 and 0x01. Status bit 1 reads the latch, and status bit 0 always reads 0.
- R4: A data or status write is carried out only while the write-enable latch is set.
- R5: Command 0x03 (read) and command 0x02 (write) take a 16-bit address, high byte first. The address then steps by one per data byte and wraps from the top address, 2^ADDR_W-1, to 0.
- R6: Address bits at and above ADDR_W are ignored. At the default ADDR_W of 12, address 0xF100 reaches the same byte as 0x0100.
- R7: Command 0x01 stores bits 7:2 of the first following byte into status bits 7:2, but not while wp_n is low. Bits 1:0 cannot be written.
- R8: While hold_n is low, so_oe is low and SCK and SI are ignored. Raising hold_n resumes the transfer at the bit where it stopped.
- R9: Any other command byte causes the rest of that selection to be ignored.
- R10: A byte written can be read back in the very next selection, with no wait.
- R11: Command 0x05 returns the status byte, and keeps repeating it for as long as clocks continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the so tri-state driver |

## Verification
The assertions assume that cs_n stays low for the whole of any hold. They also assume that hold_n and wp_n change only while SCK is steady, and that SCK is slow enough for each level to span several system clocks. The bench drives SCK with a 40 ns half period against a 5 ns system clock. It moves hold_n and wp_n only between clock phases, or while the block is deselected. It gives every hold an even number of SCK toggles, so SCK is at the same level when the pause ends as when it began.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    PH_OPC,   // command byte
    PH_AHI,   // address high byte
    PH_ALO,   // address low byte
    PH_RDAT,  // array read stream
    PH_WDAT,  // array write stream
    PH_SRD,   // status read stream
    PH_SWR,   // status write byte
    PH_SKIP   // ignore until deselect
  } phase_t;

  localparam logic [7:0] CMD_SET_WE = 8'h06;
  localparam logic [7:0] CMD_CLR_WE = 8'h04;
  localparam logic [7:0] CMD_RD_ST  = 8'h05;
  localparam logic [7:0] CMD_WR_ST  = 8'h01;
  localparam logic [7:0] CMD_RD_MEM = 8'h03;
  localparam logic [7:0] CMD_WR_MEM = 8'h02;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int HI_W = ADDR_W - 8;
  localparam int ST_W = 6;

  // synchronised pins: {cs_n, sck, si, hold_n, wp_n}
  logic [4:0] pins_s;
  logic cs_s, sck_s, si_s, hold_s, wp_s;

  spi_mem_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sck, si, hold_n, wp_n}),
    .q(pins_s)
  );
  assign {cs_s, sck_s, si_s, hold_s, wp_s} = pins_s;

  logic sck_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;

  logic active, rise_ev, fall_ev, byte_done;
  assign active  = !cs_s && hold_s;
  assign rise_ev = active && sck_s && !sck_d;
  assign fall_ev = active && !sck_s && sck_d;

  phase_t          phase;
  logic [2:0]      bit_cnt;
  logic [6:0]      shreg;
  logic [7:0]      rx_byte;
  logic [HI_W-1:0] hi_b;
  logic [ADDR_W-1:0] addr;
  logic            rd_mode, wel, clr_pend, out_en, so_r;
  logic            rd_go, rd_wait;
  logic [ST_W-1:0] st_user;
  logic [7:0]      tx_byte, stat_byte, ram_q;
  logic            ram_we, out_phase;

  assign byte_done = rise_ev && (bit_cnt == 3'd7);
  assign rx_byte   = {shreg, si_s};
  assign stat_byte = {st_user, wel, 1'b0};
  assign out_phase = (phase == PH_RDAT) || (phase == PH_SRD);
  assign ram_we    = byte_done && (phase == PH_WDAT) && wel;

  spi_mem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(addr), .wdata(rx_byte),
    .re(rd_go), .raddr(addr), .rdata(ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPC;
      bit_cnt  <= '0;
      shreg    <= '0;
      hi_b     <= '0;
      addr     <= '0;
      rd_mode  <= 1'b0;
      wel      <= 1'b0;
      clr_pend <= 1'b0;
      out_en   <= 1'b0;
      so_r     <= 1'b0;
      rd_go    <= 1'b0;
      rd_wait  <= 1'b0;
      st_user  <= '0;
      tx_byte  <= '0;
    end else begin
      rd_go   <= 1'b0;
      rd_wait <= rd_go;
      if (rd_wait) tx_byte <= ram_q;

      if (cs_s) begin
        phase    <= PH_OPC;
        bit_cnt  <= '0;
        out_en   <= 1'b0;
        clr_pend <= 1'b0;
        if (clr_pend) wel <= 1'b0;
      end else if (hold_s) begin
        if (rise_ev) begin
          bit_cnt <= bit_cnt + 3'd1;
          shreg   <= {shreg[5:0], si_s};
        end
        if (byte_done) begin
          unique case (phase)
            PH_OPC: begin
              unique case (rx_byte)
                CMD_SET_WE: begin wel <= 1'b1; phase <= PH_SKIP; end
                CMD_CLR_WE: begin clr_pend <= 1'b1; phase <= PH_SKIP; end
                CMD_RD_ST:  begin tx_byte <= stat_byte; phase <= PH_SRD; end
                CMD_WR_ST:  begin clr_pend <= 1'b1; phase <= PH_SWR; end
                CMD_RD_MEM: begin rd_mode <= 1'b1; phase <= PH_AHI; end
                CMD_WR_MEM: begin rd_mode <= 1'b0; clr_pend <= 1'b1; phase <= PH_AHI; end
                default:    phase <= PH_SKIP;
              endcase
            end
            PH_AHI: begin
              hi_b  <= rx_byte[HI_W-1:0];
              phase <= PH_ALO;
            end
            PH_ALO: begin
              addr  <= {hi_b, rx_byte};
              rd_go <= rd_mode;
              phase <= rd_mode ? PH_RDAT : PH_WDAT;
            end
            PH_RDAT: begin
              addr  <= addr + 1'b1;
              rd_go <= 1'b1;
            end
            PH_WDAT: addr <= addr + 1'b1;
            PH_SRD:  tx_byte <= stat_byte;
            PH_SWR: begin
              if (wel && wp_s) st_user <= rx_byte[7:2];
              phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
        if (fall_ev && out_phase) begin
          so_r   <= tx_byte[~bit_cnt];
          out_en <= 1'b1;
        end
      end
    end
  end

  assign so    = so_r;
  assign so_oe = out_en && !cs_s && hold_s;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int ST_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            hold_n,
  input logic            so_oe,
  input logic            cs_s,
  input logic            wp_s,
  input logic            wel,
  input logic            ram_we,
  input logic [ST_W-1:0] st_user
);
  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe); // R2
  AST_HOLD_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !$past(hold_n) && !$past(hold_n, 2)) |-> !so_oe); // R8
  AST_WP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_s |=> $stable(st_user)); // R7
  AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> wel); // R4
  AST_WEL_SET_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(cs_s)); // R3
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ST_W(6)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
  .cs_s(cs_s), .wp_s(wp_s), .wel(wel), .ram_we(ram_we), .st_user(st_user)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;
  localparam int    ADDR_W = 12;
  localparam int    HALF   = 40;
  localparam [15:0] TOPA   = 16'((1 << ADDR_W) - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_mem_slave #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic r);
    sck = 1'b0; si = b; #HALF;
    sck = 1'b1; r = so; #HALF;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      bit_io(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_begin();
    sck = mode3; #HALF;
    cs_n = 1'b0; #HALF;
  endtask

  task automatic cs_end();
    if (!mode3) begin sck = 1'b0; #HALF; end
    cs_n = 1'b1; #(4*HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    cs_begin(); xfer(op, d); cs_end();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    cs_begin(); xfer(8'h05, d); xfer(8'h00, v); cs_end();
  endtask

  task automatic wr(input logic [15:0] a, input int n,
                    input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] d;
    cs_begin(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    xfer(d0, d);
    if (n > 1) xfer(d1, d);
    if (n > 2) xfer(d2, d);
    cs_end();
  endtask

  task automatic rd(input logic [15:0] a, input int n,
                    output logic [7:0] q0, output logic [7:0] q1, output logic [7:0] q2);
    logic [7:0] d;
    q1 = 8'h00; q2 = 8'h00;
    cs_begin(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    xfer(8'h00, q0);
    if (n > 1) xfer(8'h00, q1);
    if (n > 2) xfer(8'h00, q2);
    cs_end();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 so_oe after reset", {7'd0, so_oe}, 8'h00);
    rdsr(v); chk("R3 status after reset", v, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    cmd(8'h06); rdsr(v); chk("R3 latch set", v, 8'h02);
    cmd(8'h04); rdsr(v); chk("R3 latch cleared by 0x04", v, 8'h00);
  endtask

  task automatic t_write_read_mode0();
    logic [7:0] a, b, c;
    cmd(8'h06);
    wr(16'h0100, 3, 8'h11, 8'h22, 8'h33);
    rd(16'h0100, 3, a, b, c);
    chk("R1 R10 mode0 byte0", a, 8'h11);
    chk("R5 increment byte1", b, 8'h22);
    chk("R5 increment byte2", c, 8'h33);
    rdsr(a); chk("R3 latch cleared after write", a, 8'h00);
  endtask

  task automatic t_no_latch();
    logic [7:0] a, b, c;
    wr(16'h0100, 1, 8'h99, 8'h00, 8'h00);
    rd(16'h0100, 1, a, b, c);
    chk("R4 write without latch ignored", a, 8'h11);
  endtask

  task automatic t_mode3();
    logic [7:0] a, b, c;
    mode3 = 1'b1; sck = 1'b1; #(4*HALF);
    cmd(8'h06);
    wr(16'h0200, 2, 8'h5A, 8'hC3, 8'h00);
    rd(16'h0200, 2, a, b, c);
    chk("R1 mode3 byte0", a, 8'h5A);
    chk("R1 mode3 byte1", b, 8'hC3);
    mode3 = 1'b0; sck = 1'b0; #(4*HALF);
  endtask

  task automatic t_wrap();
    logic [7:0] a, b, c;
    cmd(8'h06);
    wr(TOPA, 2, 8'hE1, 8'hE2, 8'h00);
    rd(16'h0000, 1, a, b, c);
    chk("R5 write wrapped to 0", a, 8'hE2);
    rd(TOPA, 2, a, b, c);
    chk("R5 top byte", a, 8'hE1);
    chk("R5 read wrapped to 0", b, 8'hE2);
  endtask

  task automatic t_upper();
    logic [7:0] a, b, c;
    rd(16'hF100, 1, a, b, c);
    chk("R6 upper address bits ignored", a, 8'h11);
  endtask

  task automatic t_status_write();
    logic [7:0] v, d;
    cmd(8'h06);
    cs_begin(); xfer(8'h01, d); xfer(8'hFF, d); cs_end();
    rdsr(v); chk("R7 status bits 7:2 written", v, 8'hFC);
    wp_n = 1'b0; #(4*HALF);
    cmd(8'h06);
    cs_begin(); xfer(8'h01, d); xfer(8'h00, d); cs_end();
    rdsr(v); chk("R7 protected status unchanged", v, 8'hFC);
    wp_n = 1'b1; #(4*HALF);
    cs_begin(); xfer(8'h01, d); xfer(8'h00, d); cs_end();
    rdsr(v); chk("R4 status write without latch", v, 8'hFC);
    cmd(8'h06);
    cs_begin(); xfer(8'h01, d); xfer(8'h00, d); cs_end();
    rdsr(v); chk("R7 status cleared", v, 8'h00);
  endtask

  task automatic t_status_repeat();
    logic [7:0] d, v0, v1;
    cmd(8'h06);
    cs_begin(); xfer(8'h05, d); xfer(8'h00, v0); xfer(8'h00, v1); cs_end();
    chk("R11 status first", v0, 8'h02);
    chk("R11 status repeated", v1, 8'h02);
    cmd(8'h04);
  endtask

  task automatic t_abort();
    logic [7:0] a, b, c, d;
    cmd(8'h06);
    wr(16'h0300, 1, 8'h77, 8'h00, 8'h00);
    cmd(8'h06);
    cs_begin(); xfer(8'h02, d); xfer(8'h03, d); xfer(8'h00, d);
    for (int i = 0; i < 4; i++) begin
      logic r;
      bit_io(1'b0, r);
    end
    cs_end();
    rd(16'h0300, 1, a, b, c);
    chk("R2 partial byte not written", a, 8'h77);
  endtask

  task automatic t_deselect();
    logic [7:0] d, v;
    logic oe_seen;
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic r;
      bit_io(CMD_BIT(i), r);
      oe_seen = oe_seen | so_oe;
    end
    sck = 1'b0; #(4*HALF);
    chk("R2 so_oe low while deselected", {7'd0, oe_seen}, 8'h00);
    rdsr(v); chk("R2 clocks while deselected ignored", v, 8'h00);
    d = 8'h00;
  endtask

  function automatic logic CMD_BIT(input int i);
    logic [7:0] c;
    c = 8'h06;
    return c[i];
  endfunction

  task automatic t_unknown();
    logic [7:0] d, v;
    cs_begin(); xfer(8'hAB, d); xfer(8'h06, d); cs_end();
    rdsr(v); chk("R9 unknown command ignores rest", v, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] d, q;
    cs_begin(); xfer(8'h03, d); xfer(8'h01, d); xfer(8'h00, d);
    for (int i = 7; i >= 4; i--) begin
      logic r;
      bit_io(1'b0, r);
      q[i] = r;
    end
    hold_n = 1'b0; #HALF;
    for (int k = 0; k < 2; k++) begin
      sck = 1'b0; si = 1'b1; #HALF;
      sck = 1'b1; si = 1'b0; #HALF;
    end
    chk("R8 so_oe low during hold", {7'd0, so_oe}, 8'h00);
    hold_n = 1'b1; #HALF;
    for (int i = 3; i >= 0; i--) begin
      logic r;
      bit_io(1'b0, r);
      q[i] = r;
    end
    cs_end();
    chk("R8 transfer resumes after hold", q, 8'h11);
  endtask

  initial begin
    #(200*5);
    rst_n = 1'b1;
    #(20*5);
    t_reset();
    t_latch();
    t_write_read_mode0();
    t_no_latch();
    t_mode3();
    t_wrap();
    t_upper();
    t_status_write();
    t_status_repeat();
    t_abort();
    t_deselect();
    t_unknown();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000*5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule